// File: doc/BRIEF.md
# Flash Program/Erase Protection Guard

This block sits between software and a flash program/erase engine and decides whether a requested program or erase may proceed. It keeps three protection registers: one with a bit for each of the first 32 main-region sectors, one with a bit for each eight-sector group above them, and one with a bit for each of three auxiliary regions (non-main, trim, engineering). A bit at 1 leaves its target open. A bit at 0 locks it. Software can only lower bits. Only a reset raises them again.

Each protection register carries a stored parity bit that is checked every cycle. Any mismatch sets a sticky error flag. While that flag is set, every request is refused. A read-only status word reports the error flag and the flash busy state. Requests give a registered allow/deny answer one cycle later. A test input can flip a stored parity bit to model an upset.

Top module: `fwe_guard`

## Requirements
- R1: After reset, offset 0x410 reads 0xFFFFFFFF, 0x414 reads 0x0FFFFFFF, 0x41C reads 0x00000007, and 0x420 reads 0x00000000 when `flash_busy` is low.
- R2: A bus write to 0x410, 0x414 or 0x41C stores the bitwise AND of the old contents and the write data. Writing 1 never raises a bit. Only reset restores a bit to 1.
- R3: Bits 31:28 of 0x414 and bits 31:3 of 0x41C read 0 and ignore writes. Any read of an offset other than the four listed returns 0.
- R4: Writes to 0x420 have no effect. Bit 2 of 0x420 reads the `flash_busy` input, bit 3 reads the parity error flag, and all other bits read 0.
- R5: Region code 0 is the main region. A main-region sector number s in 0..31 is allowed exactly when bit s of 0x410 is 1.
- R6: A main-region sector s in 32..255 is allowed exactly when bit (s-32)/8 of 0x414 is 1.
- R7: A main-region sector number of 256 or higher is always denied.
- R8: Region codes 1, 2 and 3 (non-main, trim, engineering) are allowed exactly when bit 0, 1 or 2 of 0x41C, respectively, is 1. The sector number is ignored.
- R9: A stored parity bit that disagrees with its register sets status bit 3 at the next clock edge. The flag stays set until reset, and reset clears it.
- R10: Any request made while the parity error flag is set is denied.
- R11: `gnt_valid` is high in exactly the cycle after a cycle with `req_valid` high. `gnt_ok` carries the answer for that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| flash_busy | input | 1 | Busy indication from the flash engine |
| tst_flip | input | 3 | Flips stored parity of sector, group or auxiliary register |
| req_valid | input | 1 | Program/erase request strobe |
| req_region | input | 2 | 0 main, 1 non-main, 2 trim, 3 engineering |
| req_sector | input | 9 | Main-region sector number |
| gnt_valid | output | 1 | Answer strobe, one cycle after request |
| gnt_ok | output | 1 | 1 = allowed, 0 = denied |

## Verification
The properties assume that reset is low from time zero and that `tst_flip` is the only source of parity disagreement. Under that assumption a mismatch can only follow an injected flip and never a register write. The bench pulses `tst_flip` for a single cycle, away from any write to the same register. It changes every input on the falling edge, so request, write and flip never race the sampling edge. Its scoreboard tracks the error flag itself from the injection time, so the expected denial does not depend on reading internal state.

// File: rtl/fwe_pkg.sv
package fwe_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_SECT = 12'h410;
  localparam logic [ADDR_W-1:0] OFF_GRP  = 12'h414;
  localparam logic [ADDR_W-1:0] OFF_AUX  = 12'h41C;
  localparam logic [ADDR_W-1:0] OFF_STAT = 12'h420;

  localparam int ST_BUSY = 2;
  localparam int ST_PERR = 3;

  typedef enum logic [1:0] {
    RG_MAIN    = 2'd0,
    RG_NONMAIN = 2'd1,
    RG_TRIM    = 2'd2,
    RG_ENGR    = 2'd3
  } region_e;
endpackage

// File: rtl/fwe_stickyreg.sv
module fwe_stickyreg #(
  parameter int W = 32,
  parameter logic [W-1:0] RST = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         flip,
  output logic [W-1:0] q,
  output logic         par_bad
);
  logic         par;
  logic [W-1:0] q_next;

  // bits may only fall; a written 1 keeps the old value
  assign q_next = q & wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= RST;
      par <= ^RST;
    end else if (wr_en) begin
      q   <= q_next;
      par <= (^q_next) ^ flip;
    end else begin
      par <= par ^ flip;
    end
  end

  assign par_bad = (^q) != par;
endmodule

// File: rtl/fwe_decide.sv
module fwe_decide
  import fwe_pkg::*;
#(
  parameter int SEC_N  = 32,
  parameter int GRP_N  = 28,
  parameter int GRP_SZ = 8,
  parameter int AUX_N  = 3,
  parameter int SECT_W = 9
) (
  input  logic [1:0]        region,
  input  logic [SECT_W-1:0] sector,
  input  logic [SEC_N-1:0]  prot_a,
  input  logic [GRP_N-1:0]  prot_b,
  input  logic [AUX_N-1:0]  prot_x,
  output logic              allow
);
  localparam int LAST   = SEC_N + GRP_N * GRP_SZ - 1;
  localparam int AIDX_W = $clog2(SEC_N);
  localparam int GIDX_W = $clog2(GRP_N);

  function automatic logic [GIDX_W-1:0] grp_of(input logic [SECT_W-1:0] s);
    logic [SECT_W-1:0] d;
    d = (s - SECT_W'(SEC_N)) / SECT_W'(GRP_SZ);
    return d[GIDX_W-1:0];
  endfunction

  logic       main_ok;
  logic [1:0] aux_idx;
  region_e    rg;

  assign rg      = region_e'(region);
  assign aux_idx = region - 2'd1;

  always_comb begin
    main_ok = 1'b0;
    if (sector < SECT_W'(SEC_N))
      main_ok = prot_a[sector[AIDX_W-1:0]];
    else if (sector <= SECT_W'(LAST))
      main_ok = prot_b[grp_of(sector)];
  end

  always_comb begin
    if (rg == RG_MAIN) allow = main_ok;
    else               allow = prot_x[aux_idx];
  end
endmodule

// File: rtl/fwe_guard.sv
module fwe_guard
  import fwe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEC_N  = 32,
  parameter int GRP_N  = 28,
  parameter int GRP_SZ = 8,
  parameter int AUX_N  = 3,
  parameter int SECT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [11:0]       bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              flash_busy,
  input  logic [2:0]        tst_flip,
  input  logic              req_valid,
  input  logic [1:0]        req_region,
  input  logic [SECT_W-1:0] req_sector,
  output logic              gnt_valid,
  output logic              gnt_ok
);
  logic [SEC_N-1:0] prot_a;
  logic [GRP_N-1:0] prot_b;
  logic [AUX_N-1:0] prot_x;
  logic [2:0]       bad;
  logic             wr_a, wr_b, wr_x;
  logic             par_mismatch;
  logic             perr;
  logic             allow;

  assign wr_a = bus_sel && bus_wr && (bus_addr == OFF_SECT);
  assign wr_b = bus_sel && bus_wr && (bus_addr == OFF_GRP);
  assign wr_x = bus_sel && bus_wr && (bus_addr == OFF_AUX);

  fwe_stickyreg #(.W(SEC_N), .RST({SEC_N{1'b1}})) u_sect (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_a), .wdata(bus_wdata[SEC_N-1:0]),
    .flip(tst_flip[0]), .q(prot_a), .par_bad(bad[0]));

  fwe_stickyreg #(.W(GRP_N), .RST({GRP_N{1'b1}})) u_grp (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_b), .wdata(bus_wdata[GRP_N-1:0]),
    .flip(tst_flip[1]), .q(prot_b), .par_bad(bad[1]));

  fwe_stickyreg #(.W(AUX_N), .RST({AUX_N{1'b1}})) u_aux (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_x), .wdata(bus_wdata[AUX_N-1:0]),
    .flip(tst_flip[2]), .q(prot_x), .par_bad(bad[2]));

  assign par_mismatch = |bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            perr <= 1'b0;
    else if (par_mismatch) perr <= 1'b1;
  end

  fwe_decide #(
    .SEC_N(SEC_N), .GRP_N(GRP_N), .GRP_SZ(GRP_SZ),
    .AUX_N(AUX_N), .SECT_W(SECT_W)
  ) u_dec (
    .region(req_region), .sector(req_sector),
    .prot_a(prot_a), .prot_b(prot_b), .prot_x(prot_x), .allow(allow));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_valid <= 1'b0;
      gnt_ok    <= 1'b0;
    end else begin
      gnt_valid <= req_valid;
      gnt_ok    <= req_valid && allow && !perr;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        OFF_SECT: bus_rdata = DATA_W'(prot_a);
        OFF_GRP:  bus_rdata = DATA_W'(prot_b);
        OFF_AUX:  bus_rdata = DATA_W'(prot_x);
        OFF_STAT: begin
          bus_rdata[ST_BUSY] = flash_busy;
          bus_rdata[ST_PERR] = perr;
        end
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/fwe_guard_chk.sv
module fwe_guard_chk #(
  parameter int SEC_N  = 32,
  parameter int SECT_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [11:0]       bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              req_valid,
  input logic [1:0]        req_region,
  input logic [SECT_W-1:0] req_sector,
  input logic              gnt_valid,
  input logic              gnt_ok,
  input logic [SEC_N-1:0]  prot_a,
  input logic              par_mismatch,
  input logic              perr
);
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((prot_a & ~$past(prot_a)) == '0));

  p_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 12'h414) |-> (bus_rdata[31:28] == 4'h0));

  p_oob_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_region == 2'd0 && req_sector >= SECT_W'(256)) |=> !gnt_ok);

  p_perr_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    par_mismatch |=> perr);

  p_perr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    perr |=> perr);

  p_deny_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && perr) |=> (gnt_valid && !gnt_ok));

  p_answer_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> gnt_valid);

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!gnt_valid && !gnt_ok));
endmodule

bind fwe_guard fwe_guard_chk #(.SEC_N(SEC_N), .SECT_W(SECT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .req_valid(req_valid),
  .req_region(req_region), .req_sector(req_sector), .gnt_valid(gnt_valid),
  .gnt_ok(gnt_ok), .prot_a(prot_a), .par_mismatch(par_mismatch), .perr(perr));

// File: tb/fwe_guard_test.sv
module fwe_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        flash_busy = 1'b0;
  logic [2:0]  tst_flip = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_region = '0;
  logic [8:0]  req_sector = '0;
  logic        gnt_valid;
  logic        gnt_ok;

  int checks = 0;
  int errors = 0;

  // bench model of the registers
  logic [31:0] m_a;
  logic [27:0] m_b;
  logic [2:0]  m_x;
  bit          m_perr;

  bit    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  fwe_guard uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flash_busy(flash_busy), .tst_flip(tst_flip), .req_valid(req_valid),
    .req_region(req_region), .req_sector(req_sector),
    .gnt_valid(gnt_valid), .gnt_ok(gnt_ok));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit model_ok(input int rg, input int s);
    if (m_perr) return 1'b0;
    if (rg == 0) begin
      if (s < 32)  return m_a[s];
      if (s < 256) return m_b[(s - 32) / 8];
      return 1'b0;
    end
    return m_x[rg - 1];
  endfunction

  function automatic void model_reset();
    m_a = 32'hFFFF_FFFF;
    m_b = 28'hFFF_FFFF;
    m_x = 3'b111;
    m_perr = 1'b0;
  endfunction

  // monitor: pops one expected answer per gnt_valid
  always @(negedge clk) begin
    if (rst_n && gnt_valid) begin
      if (exp_q.size() == 0) begin
        chk("R11 unexpected answer", 32'(gnt_valid), 32'd0);
      end else begin
        bit    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, 32'(gnt_ok), 32'(e));
      end
    end
  end

  task automatic req(input int rg, input int s, input string tag);
    @(negedge clk);
    req_valid  = 1'b1;
    req_region = 2'(rg);
    req_sector = 9'(s);
    exp_q.push_back(model_ok(rg, s));
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    case (a)
      12'h410: m_a = m_a & d;
      12'h414: m_b = m_b & d[27:0];
      12'h41C: m_x = m_x & d[2:0];
      default: ;
    endcase
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2;
    chk(tag, bus_rdata, exp);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
    chk("R11 queue drained", 32'(exp_q.size()), 32'd0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(12'h410, 32'hFFFF_FFFF, "R1 sector reg reset");
    rd(12'h414, 32'h0FFF_FFFF, "R1 group reg reset");
    rd(12'h41C, 32'h0000_0007, "R1 aux reg reset");
    rd(12'h420, 32'h0000_0000, "R1 status reset");

    req(0, 5,   "R5 open sector");
    req(0, 200, "R6 open group");
    req(1, 0,   "R8 open non-main");
    req(0, 256, "R7 beyond last sector");
    req(0, 511, "R7 max sector number");

    wr(12'h410, ~((32'd1 << 5) | (32'd1 << 31)));
    rd(12'h410, 32'h7FFF_FFDF, "R2 sector clear");
    req(0, 5,  "R5 locked sector 5");
    req(0, 4,  "R5 neighbour 4 open");
    req(0, 31, "R5 locked sector 31");
    wr(12'h410, 32'hFFFF_FFFF);
    rd(12'h410, 32'h7FFF_FFDF, "R2 write of ones ignored");

    wr(12'h414, ~(32'd1 << 3));
    req(0, 56, "R6 group 3 low edge");
    req(0, 63, "R6 group 3 high edge");
    req(0, 55, "R6 group 2 open");
    req(0, 64, "R6 group 4 open");
    wr(12'h414, 32'hFFFF_FFFF);
    rd(12'h414, 32'h0FFF_FFF7, "R3 group reserved bits zero");

    wr(12'h414, ~(32'd1 << 27));
    req(0, 248, "R6 last group low edge");
    req(0, 255, "R6 last sector");
    req(0, 247, "R6 group 26 open");

    wr(12'h41C, 32'hFFFF_FFFD);
    rd(12'h41C, 32'h0000_0005, "R3 aux reserved bits zero");
    req(2, 0,   "R8 trim locked");
    req(2, 300, "R8 trim ignores sector");
    req(1, 0,   "R8 non-main open");
    req(3, 0,   "R8 engineering open");
    wr(12'h41C, 32'hFFFF_FFFE);
    req(1, 9,   "R8 non-main locked");

    rd(12'h400, 32'h0, "R3 unmapped offset");
    wr(12'h420, 32'hFFFF_FFFF);
    rd(12'h420, 32'h0, "R4 status write ignored");
    flash_busy = 1'b1;
    rd(12'h420, 32'h4, "R4 busy bit");
    flash_busy = 1'b0;
    drain();

    @(negedge clk);
    tst_flip = 3'b010;
    @(negedge clk);
    tst_flip = 3'b000;
    m_perr = 1'b1;
    @(negedge clk);
    rd(12'h420, 32'h8, "R9 parity flag set");
    req(3, 0, "R10 deny under error");
    req(0, 4, "R10 deny open sector");
    wr(12'h414, 32'hFFFF_FFFF);
    repeat (5) @(negedge clk);
    rd(12'h420, 32'h8, "R9 flag sticky");
    drain();

    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    rd(12'h420, 32'h0, "R9 reset clears flag");
    rd(12'h410, 32'hFFFF_FFFF, "R2 reset restores bits");
    req(0, 5, "R5 open after reset");
    drain();
    chk("R11 idle no answer", 32'(gnt_valid), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule